// File: doc/BRIEF.md
# Two-Level Bounds Table Walker

This block resolves where the bounds of a pointer live in memory and moves them between a requester and memory. The requester presents a pointer address, a direction (load or store) and, for a store, a lower and an upper bound. The walker reads a directory entry at a fixed base. If that entry names a table, the walker reaches the 32-byte table entry that belongs to the pointer. On a store it writes the bounds and the pointer address into that entry. On a load it reads the entry back and returns the bounds.

Each table entry records the pointer it was written for. A load therefore returns the stored bounds only when that recorded pointer equals the requested one. Otherwise the load returns bounds that allow any address. An empty directory entry stops the walk and returns a fault that carries the address of that directory entry. Requests are handled one at a time, and memory is reached through a single request/response port with at most one access in flight.

Top module: `bnd_walker`

## Requirements
- R1: The first memory access of every request is a read of the directory entry at address DIR_BASE + ptr[47:20] * 8.
- R2: Bit 0 of a directory entry marks it valid. The table base is the entry with bits [2:0] cleared. The table entry address is table base + ptr[19:3] * 32, and a successful response reports that address on rsp_addr.
- R3: If bit 0 of the directory entry is 0, the walk ends with rsp_fault = 1 and rsp_addr = the directory entry address. No further memory access is made for that request, and in particular no write.
- R4: A store makes exactly three writes, in this order: the lower bound at entry+0, the upper bound at entry+8, then the pointer address at entry+16. It then responds with rsp_fault = 0.
- R5: A load first reads the pointer word at entry+16. If that word equals the requested pointer, the load reads entry+0 and then entry+8, and returns them as rsp_lb and rsp_ub with rsp_fault = 0.
- R6: If the pointer word read on a load differs from the requested pointer, the load responds after that single table read with rsp_lb = 0, rsp_ub = all ones and rsp_fault = 0.
- R7: req_ready is high only while the walker is idle. rsp_valid is a one-cycle pulse during which req_ready is low. A request held waiting during a response is taken in a later cycle and served correctly.
- R8: mem_req_addr, mem_req_we and mem_req_wdata stay stable while mem_req_valid is high and mem_req_ready is low. Every access, including a write, completes with one mem_rsp_valid pulse, and no new access is issued before that pulse.
- R9: After reset, req_ready = 1, mem_req_valid = 0 and rsp_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_store | input | 1 | 1 = store bounds, 0 = load bounds |
| req_ptr | input | AW | Pointer address whose bounds are walked |
| req_lb | input | AW | Lower bound to store |
| req_ub | input | AW | Upper bound to store |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address of the 64-bit word |
| mem_req_wdata | output | AW | Write data |
| mem_rsp_valid | input | 1 | Completion of the outstanding access |
| mem_rsp_rdata | input | AW | Read data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Directory entry was empty |
| rsp_addr | output | AW | Table entry address, or directory entry address on a fault |
| rsp_lb | output | AW | Returned lower bound |
| rsp_ub | output | AW | Returned upper bound |

## Verification
Completing a response and accepting the next request are the two functions that meet at the same clock edge. The bench provokes this by keeping req_valid high with a second request while the first request is still being walked. In the cycle that carries rsp_valid for the first request, it checks that req_ready is low and that the response belongs to the first request. It then checks that the waiting request is taken one cycle later and returns its own result, a mismatch response with unbounded bounds. Memory stalls and latencies of several cycles are mixed into the store and load walks, so that completion pulses and new issues fall close together.

// File: rtl/bndw_pkg.sv
package bndw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DIR_RD = 2'd1,
    ST_TBL    = 2'd2,
    ST_RESP   = 2'd3
  } bndw_state_e;

  // byte offsets of the words inside one table entry
  localparam int unsigned WOFF_LB  = 0;
  localparam int unsigned WOFF_UB  = 8;
  localparam int unsigned WOFF_PTR = 16;

endpackage

// File: rtl/bndw_addr.sv
module bndw_addr #(
  parameter int unsigned AW         = 64,
  parameter logic [63:0] DIR_BASE   = 64'h0000_1000_0000_0000,
  parameter int unsigned DIR_W      = 28,
  parameter int unsigned TBL_W      = 17,
  parameter int unsigned DIR_ESZ_LG = 3,
  parameter int unsigned TBL_ESZ_LG = 5
) (
  input  logic [DIR_W-1:0] dir_idx,
  input  logic [TBL_W-1:0] tbl_idx,
  input  logic [AW-1:0]    dir_entry,
  output logic [AW-1:0]    dir_addr,
  output logic             tbl_valid,
  output logic [AW-1:0]    entry_addr
);

  localparam logic [AW-1:0] BASE_MASK = ~((AW'(1) << DIR_ESZ_LG) - AW'(1));
  localparam logic [AW-1:0] DIR_BASE_A = DIR_BASE[AW-1:0];

  logic [AW-1:0] dir_off;
  logic [AW-1:0] tbl_off;
  logic [AW-1:0] tbl_base;

  always_comb begin
    dir_off    = {{(AW-DIR_W){1'b0}}, dir_idx} << DIR_ESZ_LG;
    tbl_off    = {{(AW-TBL_W){1'b0}}, tbl_idx} << TBL_ESZ_LG;
    dir_addr   = DIR_BASE_A + dir_off;
    tbl_valid  = dir_entry[0];
    tbl_base   = dir_entry & BASE_MASK;
    entry_addr = tbl_base + tbl_off;
  end

endmodule

// File: rtl/bndw_ctrl.sv
module bndw_ctrl
  import bndw_pkg::*;
#(
  parameter int unsigned AW     = 64,
  parameter int unsigned DIR_LO = 20,
  parameter int unsigned DIR_HI = 47,
  parameter int unsigned TBL_LO = 3,
  parameter int unsigned TBL_HI = 19,
  localparam int unsigned DIR_W = DIR_HI - DIR_LO + 1,
  localparam int unsigned TBL_W = TBL_HI - TBL_LO + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_store,
  input  logic [AW-1:0]    req_ptr,
  input  logic [AW-1:0]    req_lb,
  input  logic [AW-1:0]    req_ub,
  output logic [DIR_W-1:0] dir_idx,
  output logic [TBL_W-1:0] tbl_idx,
  input  logic [AW-1:0]    dir_addr,
  input  logic             tbl_valid,
  input  logic [AW-1:0]    entry_addr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [AW-1:0]    mem_req_addr,
  output logic [AW-1:0]    mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [AW-1:0]    mem_rsp_rdata,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [AW-1:0]    rsp_addr,
  output logic [AW-1:0]    rsp_lb,
  output logic [AW-1:0]    rsp_ub
);

  localparam logic [AW-1:0] OFF_LB  = AW'(WOFF_LB);
  localparam logic [AW-1:0] OFF_UB  = AW'(WOFF_UB);
  localparam logic [AW-1:0] OFF_PTR = AW'(WOFF_PTR);

  bndw_state_e   state;
  logic          pend;
  logic [1:0]    step;
  logic          store_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] lb_q;
  logic [AW-1:0] ub_q;
  logic [AW-1:0] dir_addr_q;
  logic [AW-1:0] entry_q;
  logic          done;

  assign req_ready = (state == ST_IDLE);
  assign done      = pend && mem_rsp_valid;

  // index source: live request while idle, latched pointer during the walk
  assign dir_idx = (state == ST_IDLE) ? req_ptr[DIR_HI:DIR_LO] : ptr_q[DIR_HI:DIR_LO];
  assign tbl_idx = ptr_q[TBL_HI:TBL_LO];

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      pend          <= 1'b0;
      step          <= 2'd0;
      store_q       <= 1'b0;
      ptr_q         <= '0;
      lb_q          <= '0;
      ub_q          <= '0;
      dir_addr_q    <= '0;
      entry_q       <= '0;
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_addr      <= '0;
      rsp_lb        <= '0;
      rsp_ub        <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_req_valid <= 1'b0;
        pend          <= 1'b1;
      end

      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            store_q       <= req_store;
            ptr_q         <= req_ptr;
            lb_q          <= req_lb;
            ub_q          <= req_ub;
            dir_addr_q    <= dir_addr;
            mem_req_valid <= 1'b1;
            mem_req_we    <= 1'b0;
            mem_req_addr  <= dir_addr;
            state         <= ST_DIR_RD;
          end
        end

        ST_DIR_RD: begin
          if (done) begin
            pend <= 1'b0;
            if (!tbl_valid) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_addr  <= dir_addr_q;
              rsp_lb    <= '0;
              rsp_ub    <= '0;
              state     <= ST_RESP;
            end else begin
              entry_q       <= entry_addr;
              step          <= 2'd0;
              mem_req_valid <= 1'b1;
              mem_req_we    <= store_q;
              mem_req_addr  <= entry_addr + (store_q ? OFF_LB : OFF_PTR);
              mem_req_wdata <= lb_q;
              state         <= ST_TBL;
            end
          end
        end

        ST_TBL: begin
          if (done) begin
            pend <= 1'b0;
            step <= step + 2'd1;
            if (store_q) begin
              case (step)
                2'd0: begin
                  mem_req_valid <= 1'b1;
                  mem_req_addr  <= entry_q + OFF_UB;
                  mem_req_wdata <= ub_q;
                end
                2'd1: begin
                  mem_req_valid <= 1'b1;
                  mem_req_addr  <= entry_q + OFF_PTR;
                  mem_req_wdata <= ptr_q;
                end
                default: begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b0;
                  rsp_addr  <= entry_q;
                  rsp_lb    <= lb_q;
                  rsp_ub    <= ub_q;
                  state     <= ST_RESP;
                end
              endcase
            end else begin
              case (step)
                2'd0: begin
                  if (mem_rsp_rdata != ptr_q) begin
                    rsp_valid <= 1'b1;
                    rsp_fault <= 1'b0;
                    rsp_addr  <= entry_q;
                    rsp_lb    <= '0;
                    rsp_ub    <= '1;
                    state     <= ST_RESP;
                  end else begin
                    mem_req_valid <= 1'b1;
                    mem_req_addr  <= entry_q + OFF_LB;
                  end
                end
                2'd1: begin
                  lb_q          <= mem_rsp_rdata;
                  mem_req_valid <= 1'b1;
                  mem_req_addr  <= entry_q + OFF_UB;
                end
                default: begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b0;
                  rsp_addr  <= entry_q;
                  rsp_lb    <= lb_q;
                  rsp_ub    <= mem_rsp_rdata;
                  state     <= ST_RESP;
                end
              endcase
            end
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)); // R8

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    pend |-> !mem_req_valid); // R8

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R7

  AST_BUSY_DURING_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R7

  AST_WRITE_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_we |-> store_q && state == ST_TBL); // R4

  AST_FAULT_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> $past(mem_rsp_valid) && !$past(mem_rsp_rdata[0])); // R3

endmodule

// File: rtl/bnd_walker.sv
module bnd_walker #(
  parameter int unsigned AW       = 64,
  parameter logic [63:0] DIR_BASE = 64'h0000_1000_0000_0000,
  parameter int unsigned DIR_LO   = 20,
  parameter int unsigned DIR_HI   = 47,
  parameter int unsigned TBL_LO   = 3,
  localparam int unsigned TBL_HI     = DIR_LO - 1,
  localparam int unsigned DIR_W      = DIR_HI - DIR_LO + 1,
  localparam int unsigned TBL_W      = TBL_HI - TBL_LO + 1,
  localparam int unsigned DIR_ESZ_LG = 3,
  localparam int unsigned TBL_ESZ_LG = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_store,
  input  logic [AW-1:0] req_ptr,
  input  logic [AW-1:0] req_lb,
  input  logic [AW-1:0] req_ub,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [AW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_rdata,
  output logic          rsp_valid,
  output logic          rsp_fault,
  output logic [AW-1:0] rsp_addr,
  output logic [AW-1:0] rsp_lb,
  output logic [AW-1:0] rsp_ub
);

  logic [DIR_W-1:0] dir_idx;
  logic [TBL_W-1:0] tbl_idx;
  logic [AW-1:0]    dir_addr;
  logic             tbl_valid;
  logic [AW-1:0]    entry_addr;

  bndw_addr #(
    .AW(AW), .DIR_BASE(DIR_BASE), .DIR_W(DIR_W), .TBL_W(TBL_W),
    .DIR_ESZ_LG(DIR_ESZ_LG), .TBL_ESZ_LG(TBL_ESZ_LG)
  ) u_addr (
    .dir_idx   (dir_idx),
    .tbl_idx   (tbl_idx),
    .dir_entry (mem_rsp_rdata),
    .dir_addr  (dir_addr),
    .tbl_valid (tbl_valid),
    .entry_addr(entry_addr)
  );

  bndw_ctrl #(
    .AW(AW), .DIR_LO(DIR_LO), .DIR_HI(DIR_HI), .TBL_LO(TBL_LO), .TBL_HI(TBL_HI)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_store    (req_store),
    .req_ptr      (req_ptr),
    .req_lb       (req_lb),
    .req_ub       (req_ub),
    .dir_idx      (dir_idx),
    .tbl_idx      (tbl_idx),
    .dir_addr     (dir_addr),
    .tbl_valid    (tbl_valid),
    .entry_addr   (entry_addr),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_we   (mem_req_we),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_addr     (rsp_addr),
    .rsp_lb       (rsp_lb),
    .rsp_ub       (rsp_ub)
  );

endmodule

// File: tb/bnd_walker_tb.sv
module bnd_walker_tb;

  localparam logic [63:0] DBASE = 64'h0000_1000_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [63:0] req_ptr = '0, req_lb = '0, req_ub = '0;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_rdata;
  logic        rsp_valid, rsp_fault;
  logic [63:0] rsp_addr, rsp_lb, rsp_ub;

  always #5 clk = ~clk;

  bnd_walker #(.DIR_BASE(DBASE)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_ptr(req_ptr), .req_lb(req_lb), .req_ub(req_ub),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
    .rsp_lb(rsp_lb), .rsp_ub(rsp_ub)
  );

  // ---------------- memory model ----------------
  logic [63:0] mem [logic [63:0]];
  int          lat = 1;
  bit          stall = 1'b0;
  logic        rdy_q = 1'b1;
  int          lat_cnt = 0;
  logic [63:0] pend_data = '0;
  logic        pre_we = 1'b0;
  logic [63:0] pre_addr = '0, pre_data = '0;
  int          log_n = 0;
  logic [63:0] log_addr [64];
  logic [63:0] log_data [64];
  logic        log_we   [64];

  assign mem_req_ready = rdy_q;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst) begin
      lat_cnt       <= 0;
      rdy_q         <= 1'b1;
      mem_rsp_rdata <= '0;
    end else begin
      rdy_q <= stall ? ~rdy_q : 1'b1;
      if (pre_we) mem[pre_addr] = pre_data;
      if (lat_cnt != 0) begin
        lat_cnt <= lat_cnt - 1;
        if (lat_cnt == 1) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= pend_data;
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        log_addr[log_n % 64] = mem_req_addr;
        log_data[log_n % 64] = mem_req_wdata;
        log_we[log_n % 64]   = mem_req_we;
        log_n = log_n + 1;
        if (mem_req_we) mem[mem_req_addr] = mem_req_wdata;
        else pend_data <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
        lat_cnt <= lat;
      end
    end
  end

  // ---------------- checking helpers ----------------
  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] dir_of(input logic [63:0] p);
    return DBASE + ({36'd0, p[47:20]} << 3);
  endfunction

  function automatic logic [63:0] ent_of(input logic [63:0] dentry, input logic [63:0] p);
    return (dentry & ~64'h7) + ({47'd0, p[19:3]} << 5);
  endfunction

  task automatic poke(input logic [63:0] a, input logic [63:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  logic        r_fault;
  logic [63:0] r_addr, r_lb, r_ub;

  task automatic wait_rsp();
    int t = 0;
    while (!rsp_valid && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk("R7", "response arrived", {63'd0, rsp_valid}, 64'd1);
    r_fault = rsp_fault; r_addr = rsp_addr; r_lb = rsp_lb; r_ub = rsp_ub;
  endtask

  task automatic run_req(input bit st, input logic [63:0] p, input logic [63:0] lb, input logic [63:0] ub);
    @(negedge clk);
    req_store = st; req_ptr = p; req_lb = lb; req_ub = ub; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp();
  endtask

  // ---------------- scenario data ----------------
  localparam logic [63:0] PA   = 64'h0000_1234_5678_9AB8;
  localparam logic [63:0] PB   = PA ^ (64'h1 << 60);
  localparam logic [63:0] PC   = 64'h0000_7777_0000_0040;
  localparam logic [63:0] DENA = 64'h0000_2000_0000_0003;
  localparam logic [63:0] DENC = 64'h0000_3000_0000_0002;

  task automatic t_reset();
    chk("R9", "req_ready", {63'd0, req_ready}, 64'd1);
    chk("R9", "mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
    chk("R9", "rsp_valid", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_store(input logic [63:0] lb, input logic [63:0] ub);
    int b = log_n;
    logic [63:0] e = ent_of(DENA, PA);
    run_req(1'b1, PA, lb, ub);
    chk("R4", "store fault", {63'd0, r_fault}, 64'd0);
    chk("R2", "store entry addr", r_addr, e);
    chk("R4", "store access count", 64'(log_n - b), 64'd4);
    chk("R1", "dir read addr", log_addr[b % 64], dir_of(PA));
    chk("R1", "dir read is read", {63'd0, log_we[b % 64]}, 64'd0);
    chk("R4", "write1 addr", log_addr[(b+1) % 64], e);
    chk("R4", "write1 data", log_data[(b+1) % 64], lb);
    chk("R4", "write2 addr", log_addr[(b+2) % 64], e + 64'd8);
    chk("R4", "write2 data", log_data[(b+2) % 64], ub);
    chk("R4", "write3 addr", log_addr[(b+3) % 64], e + 64'd16);
    chk("R4", "write3 data", log_data[(b+3) % 64], PA);
    chk("R4", "writes flagged", {61'd0, log_we[(b+1)%64], log_we[(b+2)%64], log_we[(b+3)%64]}, 64'd7);
    @(negedge clk);
    chk("R7", "rsp_valid single cycle", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_load_hit(input logic [63:0] lb, input logic [63:0] ub);
    int b = log_n;
    logic [63:0] e = ent_of(DENA, PA);
    run_req(1'b0, PA, 64'hdead, 64'hbeef);
    chk("R5", "load fault", {63'd0, r_fault}, 64'd0);
    chk("R5", "load lb", r_lb, lb);
    chk("R5", "load ub", r_ub, ub);
    chk("R5", "load access count", 64'(log_n - b), 64'd4);
    chk("R5", "first table read at ptr word", log_addr[(b+1) % 64], e + 64'd16);
    chk("R5", "second table read at lb", log_addr[(b+2) % 64], e);
    chk("R5", "third table read at ub", log_addr[(b+3) % 64], e + 64'd8);
  endtask

  task automatic t_load_miss();
    int b = log_n;
    run_req(1'b0, PB, '0, '0);
    chk("R6", "miss fault", {63'd0, r_fault}, 64'd0);
    chk("R6", "miss lb", r_lb, 64'd0);
    chk("R6", "miss ub", r_ub, '1);
    chk("R6", "miss access count", 64'(log_n - b), 64'd2);
  endtask

  task automatic t_empty_dir();
    int b = log_n;
    run_req(1'b0, PC, '0, '0);
    chk("R3", "load fault flag", {63'd0, r_fault}, 64'd1);
    chk("R3", "load fault addr", r_addr, dir_of(PC));
    chk("R3", "load access count", 64'(log_n - b), 64'd1);
    b = log_n;
    run_req(1'b1, PC, 64'h10, 64'h20);
    chk("R3", "store fault flag", {63'd0, r_fault}, 64'd1);
    chk("R3", "store fault addr", r_addr, dir_of(PC));
    chk("R3", "store made no write", 64'(log_n - b), 64'd1);
  endtask

  task automatic t_back_to_back(input logic [63:0] lb, input logic [63:0] ub);
    @(negedge clk);
    req_store = 1'b0; req_ptr = PA; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_ptr = PB;  // second request waits with valid held high
    wait_rsp();
    chk("R7", "ready low with response", {63'd0, req_ready}, 64'd0);
    chk("R7", "first response lb", r_lb, lb);
    chk("R7", "first response ub", r_ub, ub);
    @(negedge clk);
    chk("R7", "ready back after response", {63'd0, req_ready}, 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp();
    chk("R7", "second response lb", r_lb, 64'd0);
    chk("R7", "second response ub", r_ub, '1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    poke(dir_of(PA), DENA);
    poke(dir_of(PC), DENC);

    t_store(64'h0000_4000_0000_1000, 64'h0000_4000_0000_1FFF);
    t_load_hit(64'h0000_4000_0000_1000, 64'h0000_4000_0000_1FFF);
    t_load_miss();
    t_empty_dir();

    // stalled, slow memory (R8)
    stall = 1'b1; lat = 3;
    t_store(64'h0000_5000_0000_0000, 64'h0000_5000_0000_00FF);
    t_load_hit(64'h0000_5000_0000_0000, 64'h0000_5000_0000_00FF);
    chk("R8", "stalled walk mem state", mem[ent_of(DENA, PA) + 64'd8], 64'h0000_5000_0000_00FF);
    lat = 2;
    t_back_to_back(64'h0000_5000_0000_0000, 64'h0000_5000_0000_00FF);
    stall = 1'b0; lat = 1;
    t_back_to_back(64'h0000_5000_0000_0000, 64'h0000_5000_0000_00FF);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
    $finish;
  end

endmodule